// File: doc/BRIEF.md
# Instruction Format and Constant-Generator Decoder

This block looks at one 16-bit instruction word of a two-address microcontroller and breaks it into its fields. It sorts the word into one of three formats from its top nibble: dual-operand, single-operand or relative jump. The single zero-operand return-from-interrupt word and words with a top nibble of zero are reported on their own flags. For operand-bearing words it pulls out the opcode, register numbers, addressing modes and the byte/word flag.

The decoder also spots the source encodings where a small constant comes from a constant-generator register instead of an extension word. It then counts the extension words (0, 1 or 2) that must follow the opcode word. A fetch unit uses that count to step past the instruction and to know which following words carry a source or destination offset.

Words enter on a valid/ready stream and leave, one cycle later, from a register stage on a second valid/ready stream. A word is taken when `in_valid` and `in_ready` are both high. The stage can take a word whenever it is empty or its current result is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the decoded result stays frozen and `in_ready` stays low. Operand fetch, memory access and execution belong to other blocks.

Top module: `insn_fmt_decoder`

## Requirements
- R1: Formats are encoded as 0 dual, 1 single, 2 jump, 3 none on `out_fmt`. Top nibble 4..F gives dual, 1 gives single and 2..3 gives jump. Top nibble 0 gives format 3 with `out_illegal` high and every field output zero.
- R2: The exact word 0x1300 gives format 3 with `out_reti` high, `out_illegal` low, an extension count of 0 and every field output zero.
- R3: For a dual word, fields come from these bits: `out_opcode` = bits 15:12, `out_src_reg` = 11:8, `out_dst_mode` = 7, `out_byte` = 6, `out_src_mode` = 5:4, `out_dst_reg` = 3:0.
- R4: For a single-operand word, `out_opcode` = {0, bits 9:7}. Both register outputs carry bits 3:0, `out_src_mode` = 5:4, `out_byte` = 6 and `out_dst_mode` = 0. For a jump word, `out_opcode` = {0, bits 12:10} and `out_jump_off` = bits 9:0, with every other field zero.
- R5: An operand on register 3 is always a generated constant (`out_const_hit` = 1, no extension word). Mode 0 gives 0, mode 1 gives 1, mode 2 gives 2 and mode 3 gives all ones.
- R6: An operand on register 2 behaves by mode. Mode 2 gives constant 4 and mode 3 gives constant 8, both without an extension word. Mode 1 is an absolute address (`out_src_abs` = 1, base value zero) with one extension word. Mode 0 is a plain register.
- R7: In byte mode (bit 6 = 1) a generated constant has its upper eight bits forced to zero, so all ones becomes 0x00FF.
- R8: `out_ext_words` is the sum of a source part and a destination part. The source part is 1 for mode 1 on any register other than 3, or for mode 3 on register 0. The destination part is 1 when a dual word has bit 7 set. The count is 0 for jumps, return-from-interrupt and illegal words.
- R9: A word accepted in one cycle appears on the outputs with `out_valid` high after the next clock edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, all outputs hold steady.
- R10: During and straight after reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Decoder can accept a word |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Consumer takes the result |
| out_fmt | output | 2 | Format code |
| out_illegal | output | 1 | Top nibble was zero |
| out_reti | output | 1 | Return-from-interrupt word |
| out_opcode | output | 4 | Operation field |
| out_src_reg | output | 4 | Source (or sole operand) register |
| out_dst_reg | output | 4 | Destination register |
| out_src_mode | output | 2 | Source addressing mode |
| out_dst_mode | output | 1 | Destination addressing mode |
| out_byte | output | 1 | Byte-size operation |
| out_const_hit | output | 1 | Source is a generated constant |
| out_const_val | output | 16 | Generated constant value |
| out_src_abs | output | 1 | Source is absolute through register 2 |
| out_ext_words | output | 2 | Extension words that follow |
| out_jump_off | output | 10 | Signed jump word offset |

## Verification
The bench sweeps every one of the 65536 input words and compares each field group against a model built from the requirements. The sweep covers the register 2 and register 3 encodings and the register 0 immediate case. A design that counted an extension word for a generated constant, or missed the register 0 immediate, would give the wrong length. Several boundaries are exercised: nibble 0 against 1, the lone 0x1300 among the other 0x13xx words, and byte-mode all-ones. A design that masked the constant the wrong way or treated 0x13xx as a range would fail there. A back-pressure sequence checks that a stalled result is neither overwritten nor dropped.

// File: rtl/ifd_pkg.sv
`timescale 1ns/1ps
package ifd_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned REG_W  = 4;
  localparam int unsigned OFF_W  = 10;

  typedef enum logic [1:0] {
    FMT_DUAL   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_JUMP   = 2'd2,
    FMT_NONE   = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e              fmt;
    logic              illegal;
    logic              reti;
    logic [3:0]        opcode;
    logic [REG_W-1:0]  src_reg;
    logic [REG_W-1:0]  dst_reg;
    logic [1:0]        src_mode;
    logic              dst_mode;
    logic              byte_op;
    logic              const_hit;
    logic [WORD_W-1:0] const_val;
    logic              src_abs;
    logic [1:0]        ext_words;
    logic [OFF_W-1:0]  jump_off;
  } dec_t;
endpackage

// File: rtl/ifd_class.sv
`timescale 1ns/1ps
module ifd_class
  import ifd_pkg::*;
#(
  parameter logic [WORD_W-1:0] RETI_WORD = 16'h1300
) (
  input  logic [WORD_W-1:0] word,
  output fmt_e              fmt,
  output logic              illegal,
  output logic              reti
);
  localparam int unsigned NIB_LSB = WORD_W - 4;

  logic [3:0] top_nib;
  assign top_nib = word[WORD_W-1:NIB_LSB];

  always_comb begin
    fmt     = FMT_DUAL;
    illegal = 1'b0;
    reti    = 1'b0;
    unique case (top_nib)
      4'h0: begin
        fmt     = FMT_NONE;
        illegal = 1'b1;
      end
      4'h1: begin
        if (word == RETI_WORD) begin
          fmt  = FMT_NONE;
          reti = 1'b1;
        end else begin
          fmt = FMT_SINGLE;
        end
      end
      4'h2, 4'h3: fmt = FMT_JUMP;
      default:    fmt = FMT_DUAL;
    endcase
  end
endmodule

// File: rtl/ifd_operand.sv
`timescale 1ns/1ps
module ifd_operand #(
  parameter int unsigned REG_W  = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PC_REG = 0,
  parameter int unsigned SR_REG = 2,
  parameter int unsigned CG_REG = 3
) (
  input  logic              en,
  input  logic [1:0]        mode,
  input  logic [REG_W-1:0]  rnum,
  input  logic              byte_op,
  output logic              const_hit,
  output logic [DATA_W-1:0] const_val,
  output logic              abs_addr,
  output logic              ext
);
  localparam logic [REG_W-1:0]  PC_R = REG_W'(PC_REG);
  localparam logic [REG_W-1:0]  SR_R = REG_W'(SR_REG);
  localparam logic [REG_W-1:0]  CG_R = REG_W'(CG_REG);
  localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic [DATA_W-1:0] raw;

  always_comb begin
    const_hit = 1'b0;
    raw       = '0;
    abs_addr  = 1'b0;
    ext       = 1'b0;
    if (en) begin
      if (rnum == CG_R) begin
        const_hit = 1'b1;
        unique case (mode)
          2'b00:   raw = '0;
          2'b01:   raw = DATA_W'(1);
          2'b10:   raw = DATA_W'(2);
          default: raw = '1;
        endcase
      end else if (rnum == SR_R) begin
        unique case (mode)
          2'b01: begin
            abs_addr = 1'b1;
            ext      = 1'b1;
          end
          2'b10: begin
            const_hit = 1'b1;
            raw       = DATA_W'(4);
          end
          2'b11: begin
            const_hit = 1'b1;
            raw       = DATA_W'(8);
          end
          default: ;
        endcase
      end else if (mode == 2'b01) begin
        ext = 1'b1;
      end else if (mode == 2'b11 && rnum == PC_R) begin
        ext = 1'b1;
      end
    end
    const_val = byte_op ? (raw & LOW_MASK) : raw;
  end
endmodule

// File: rtl/ifd_stage.sv
`timescale 1ns/1ps
module ifd_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) out_data <= in_data;
    end
  end
endmodule

// File: rtl/insn_fmt_decoder.sv
`timescale 1ns/1ps
module insn_fmt_decoder
  import ifd_pkg::*;
#(
  parameter int unsigned PC_REG = 0,
  parameter int unsigned SR_REG = 2,
  parameter int unsigned CG_REG = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_word,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [1:0]  out_fmt,
  output logic        out_illegal,
  output logic        out_reti,
  output logic [3:0]  out_opcode,
  output logic [3:0]  out_src_reg,
  output logic [3:0]  out_dst_reg,
  output logic [1:0]  out_src_mode,
  output logic        out_dst_mode,
  output logic        out_byte,
  output logic        out_const_hit,
  output logic [15:0] out_const_val,
  output logic        out_src_abs,
  output logic [1:0]  out_ext_words,
  output logic [9:0]  out_jump_off
);
  localparam int unsigned DEC_W = $bits(dec_t);

  fmt_e              fmt;
  logic              ill, reti;
  logic              op_en, op_hit, op_abs, op_ext, dst_ext;
  logic [REG_W-1:0]  op_reg;
  logic [WORD_W-1:0] op_val;
  dec_t              dec_d, dec_q;
  logic [DEC_W-1:0]  stage_q;

  ifd_class u_class (
    .word    (in_word),
    .fmt     (fmt),
    .illegal (ill),
    .reti    (reti)
  );

  assign op_en   = (fmt == FMT_DUAL) || (fmt == FMT_SINGLE);
  assign op_reg  = (fmt == FMT_DUAL) ? in_word[11:8] : in_word[3:0];
  assign dst_ext = (fmt == FMT_DUAL) && in_word[7];

  ifd_operand #(
    .REG_W  (REG_W),
    .DATA_W (WORD_W),
    .BYTE_W (WORD_W / 2),
    .PC_REG (PC_REG),
    .SR_REG (SR_REG),
    .CG_REG (CG_REG)
  ) u_src (
    .en        (op_en),
    .mode      (in_word[5:4]),
    .rnum      (op_reg),
    .byte_op   (in_word[6]),
    .const_hit (op_hit),
    .const_val (op_val),
    .abs_addr  (op_abs),
    .ext       (op_ext)
  );

  always_comb begin
    dec_d         = '0;
    dec_d.fmt     = fmt;
    dec_d.illegal = ill;
    dec_d.reti    = reti;
    unique case (fmt)
      FMT_DUAL: begin
        dec_d.opcode   = in_word[15:12];
        dec_d.src_reg  = in_word[11:8];
        dec_d.dst_reg  = in_word[3:0];
        dec_d.src_mode = in_word[5:4];
        dec_d.dst_mode = in_word[7];
        dec_d.byte_op  = in_word[6];
      end
      FMT_SINGLE: begin
        dec_d.opcode   = {1'b0, in_word[9:7]};
        dec_d.src_reg  = in_word[3:0];
        dec_d.dst_reg  = in_word[3:0];
        dec_d.src_mode = in_word[5:4];
        dec_d.byte_op  = in_word[6];
      end
      FMT_JUMP: begin
        dec_d.opcode   = {1'b0, in_word[12:10]};
        dec_d.jump_off = in_word[OFF_W-1:0];
      end
      default: ;
    endcase
    dec_d.const_hit = op_hit;
    dec_d.const_val = op_val;
    dec_d.src_abs   = op_abs;
    dec_d.ext_words = {1'b0, op_ext} + {1'b0, dst_ext};
  end

  ifd_stage #(.W(DEC_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (dec_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (stage_q)
  );

  assign dec_q         = dec_t'(stage_q);
  assign out_fmt       = dec_q.fmt;
  assign out_illegal   = dec_q.illegal;
  assign out_reti      = dec_q.reti;
  assign out_opcode    = dec_q.opcode;
  assign out_src_reg   = dec_q.src_reg;
  assign out_dst_reg   = dec_q.dst_reg;
  assign out_src_mode  = dec_q.src_mode;
  assign out_dst_mode  = dec_q.dst_mode;
  assign out_byte      = dec_q.byte_op;
  assign out_const_hit = dec_q.const_hit;
  assign out_const_val = dec_q.const_val;
  assign out_src_abs   = dec_q.src_abs;
  assign out_ext_words = dec_q.ext_words;
  assign out_jump_off  = dec_q.jump_off;
endmodule

// File: rtl/ifd_checker.sv
`timescale 1ns/1ps
module ifd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] in_word,
  input logic        out_valid,
  input logic        out_ready,
  input logic [1:0]  out_fmt,
  input logic        out_illegal,
  input logic        out_reti,
  input logic [3:0]  out_dst_reg,
  input logic        out_const_hit,
  input logic [15:0] out_const_val,
  input logic        out_dst_mode,
  input logic [1:0]  out_ext_words
);
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_fmt, out_dst_reg, out_const_val, out_ext_words}));

  a_r9_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r1_illegal_fmt: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_fmt == 2'd3 && !out_reti && out_ext_words == 2'd0);

  a_r8_jump_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fmt == 2'd2 |-> out_ext_words == 2'd0 && !out_const_hit);

  a_r5_const_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_const_hit |-> out_ext_words == {1'b0, out_dst_mode});

  a_r3_dst_field: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_word[15:14] != 2'b00 |=> out_dst_reg == $past(in_word[3:0]));
endmodule

bind insn_fmt_decoder ifd_checker u_ifd_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_word       (in_word),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_fmt       (out_fmt),
  .out_illegal   (out_illegal),
  .out_reti      (out_reti),
  .out_dst_reg   (out_dst_reg),
  .out_const_hit (out_const_hit),
  .out_const_val (out_const_val),
  .out_dst_mode  (out_dst_mode),
  .out_ext_words (out_ext_words)
);

// File: tb/insn_fmt_decoder_test.sv
`timescale 1ns/1ps
module insn_fmt_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [15:0] in_word;
  logic [1:0]  out_fmt, out_src_mode, out_ext_words;
  logic        out_illegal, out_reti, out_dst_mode, out_byte, out_const_hit, out_src_abs;
  logic [3:0]  out_opcode, out_src_reg, out_dst_reg;
  logic [15:0] out_const_val;
  logic [9:0]  out_jump_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  insn_fmt_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_fmt(out_fmt),
    .out_illegal(out_illegal), .out_reti(out_reti), .out_opcode(out_opcode),
    .out_src_reg(out_src_reg), .out_dst_reg(out_dst_reg), .out_src_mode(out_src_mode),
    .out_dst_mode(out_dst_mode), .out_byte(out_byte), .out_const_hit(out_const_hit),
    .out_const_val(out_const_val), .out_src_abs(out_src_abs),
    .out_ext_words(out_ext_words), .out_jump_off(out_jump_off)
  );

  typedef struct packed {
    logic [1:0]  fmt;
    logic        ill, reti;
    logic [3:0]  opc, sreg, dreg;
    logic [1:0]  smode;
    logic        dmode, byt, chit;
    logic [15:0] cval;
    logic        sabs;
    logic [1:0]  ext;
    logic [9:0]  joff;
  } exp_t;

  function automatic exp_t model(input logic [15:0] w);
    exp_t e = '0;
    int   nib = w[15:12];
    int   r, m;
    logic opnd = 1'b0;
    if (nib == 0) begin e.fmt = 3; e.ill = 1; end
    else if (w == 16'h1300) begin e.fmt = 3; e.reti = 1; end
    else if (nib == 1) begin
      e.fmt = 1; e.opc = {1'b0, w[9:7]}; e.sreg = w[3:0]; e.dreg = w[3:0];
      e.smode = w[5:4]; e.byt = w[6]; opnd = 1;
    end else if (nib < 4) begin
      e.fmt = 2; e.opc = {1'b0, w[12:10]}; e.joff = w[9:0];
    end else begin
      e.fmt = 0; e.opc = w[15:12]; e.sreg = w[11:8]; e.dreg = w[3:0];
      e.smode = w[5:4]; e.dmode = w[7]; e.byt = w[6]; opnd = 1;
    end
    if (opnd) begin
      r = e.sreg; m = e.smode;
      if (r == 3) begin
        e.chit = 1;
        e.cval = (m == 3) ? 16'hFFFF : 16'(m);
      end else if (r == 2 && m >= 2) begin
        e.chit = 1;
        e.cval = (m == 2) ? 16'd4 : 16'd8;
      end else if (r == 2 && m == 1) begin
        e.sabs = 1; e.ext = 1;
      end else if (m == 1 || (m == 3 && r == 0)) begin
        e.ext = 1;
      end
      if (e.byt) e.cval[15:8] = 8'h00;
      if (e.fmt == 0 && w[7]) e.ext = e.ext + 2'd1;
    end
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] w,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s word=%h actual=%h expected=%h", req, w, act, exp);
    end
  endtask

  task automatic check_word(input logic [15:0] w);
    exp_t e = model(w);
    string tg;
    chk(out_valid == 1'b1, "R9", w, 32'(out_valid), 32'd1);
    chk({out_fmt, out_illegal} == {e.fmt, e.ill}, "R1", w,
        32'({out_fmt, out_illegal}), 32'({e.fmt, e.ill}));
    chk(out_reti == e.reti, "R2", w, 32'(out_reti), 32'(e.reti));
    tg = (e.fmt == 0) ? "R3" : "R4";
    chk({out_opcode, out_src_reg, out_dst_reg, out_src_mode, out_dst_mode, out_byte, out_jump_off}
        == {e.opc, e.sreg, e.dreg, e.smode, e.dmode, e.byt, e.joff}, tg, w,
        32'({out_opcode, out_src_reg, out_dst_reg, out_src_mode, out_dst_mode, out_byte, out_jump_off}),
        32'({e.opc, e.sreg, e.dreg, e.smode, e.dmode, e.byt, e.joff}));
    tg = (e.chit && e.byt) ? "R7" : (e.sreg == 2) ? "R6" : "R5";
    chk({out_const_hit, out_const_val, out_src_abs} == {e.chit, e.cval, e.sabs}, tg, w,
        32'({out_const_hit, out_const_val, out_src_abs}), 32'({e.chit, e.cval, e.sabs}));
    chk(out_ext_words == e.ext, "R8", w, 32'(out_ext_words), 32'(e.ext));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_word = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10", 16'h0,
        32'({out_valid, in_ready}), 32'b01);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R10", 16'h0,
        32'({out_valid, in_ready}), 32'b01);

    // Exhaustive sweep: one word per cycle, full throughput (R1..R9)
    for (int i = 0; i < 65536; i++) begin
      in_word  = 16'(i);
      in_valid = 1'b1;
      @(negedge clk);
      check_word(16'(i));
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", 16'h0, 32'(out_valid), 32'd0);

    // Back-pressure: stalled result must hold, next word must not slip in (R9)
    out_ready = 1'b0;
    in_word = 16'h4375; in_valid = 1'b1;
    @(negedge clk);
    check_word(16'h4375);
    chk(in_ready == 1'b0, "R9", 16'h4375, 32'(in_ready), 32'd0);
    in_word = 16'h2ABC;
    @(negedge clk);
    check_word(16'h4375);
    @(negedge clk);
    check_word(16'h4375);
    out_ready = 1'b1;
    #0.5;
    chk(in_ready == 1'b1, "R9", 16'h2ABC, 32'(in_ready), 32'd1);
    @(negedge clk);
    check_word(16'h2ABC);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", 16'h0, 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule